// File: doc/BRIEF.md
# Vector control and status register file

This block holds the control and status registers of a vector unit and answers the core's register-access port for them. A 12-bit register address is decoded every cycle. A read strobe returns the selected register, zero-extended to the machine word width. A write strobe stores new data and returns the value that was actually kept. An address-hit flag shows whether the address belongs to this bank, so the surrounding pipeline can raise an illegal-instruction condition when it does not.

The bank holds seven architectural views:

- the element start index;
- the saturation flag;
- the rounding mode;
- the combined fixed-point control word;
- the vector length;
- the vector type;
- the register length in bytes.

The saturation flag and the rounding mode are not separate registers. They are the two fields of one 3-bit fixed-point control word. A write through either alias address changes only its own field and leaves the other field untouched.

All outputs are registered, so results appear one clock after the strobe. The word width and the base-2 logarithm of the vector register length are parameters.

Top module: `vec_ctl_regs`

## Requirements
- R1: `addr_hit` is 1 one cycle after a read or write strobe whose address is one of 0x008 (start index), 0x009 (saturation), 0x00A (rounding), 0x00F (fixed-point word), 0xC20 (length), 0xC21 (type) or 0xC22 (length in bytes). It is 0 for any other address, and 0 after a cycle with no strobe.
- R2: A read of an address outside that set returns 0 on `rd_data`.
- R3: The fixed-point word keeps the rounding mode in bits [2:1] and the saturation flag in bit 0. A read of 0x009 returns bit 0, a read of 0x00A returns bits [2:1] in the low two bits, and a read of 0x00F returns all three bits. Every read is zero-extended to XLEN.
- R4: A write to 0x009 loads the saturation flag from write-data bit 0 and leaves the rounding mode unchanged.
- R5: A write to 0x00A loads the rounding mode from write-data bits [1:0] and leaves the saturation flag unchanged.
- R6: A write to 0x00F loads the rounding mode from write-data bits [2:1] and the saturation flag from bit 0.
- R7: The start index is 16 bits wide. A write keeps only the low VLEN_LOG bits of the data, and all higher bits read as 0.
- R8: Writes to 0xC20, 0xC21 and 0xC22 store the full XLEN-bit data.
- R9: One cycle after a write strobe, `wr_result` shows the value as stored, in the same form as a read of that address. It is 0 after a write to an undefined address and after a cycle without a write strobe.
- R10: After reset, the start index, length, rounding mode and saturation flag are 0. The type register holds only its illegal-configuration bit (bit XLEN-1) set. The length-in-bytes register holds 2^VLEN_LOG/8.
- R11: A read and a write to the same address in the same cycle return the value from before the write. The new value is returned by a read in the following cycle.
- R12: `rd_data` is 0 one cycle after any cycle in which `rd_en` is low.
- R13: A write to an undefined address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | XLEN | Write data |
| rd_data | output | XLEN | Registered read data |
| addr_hit | output | 1 | Registered address-defined flag |
| wr_result | output | XLEN | Registered value stored by the last write |

## Verification
The hardest situation to reach is a partial write through one alias while the other field holds a non-zero value. Only then does a design that overwrites the whole 3-bit word show a difference. The stimulus therefore preloads every one of the eight combined-word values through 0x00F. After each preload it writes both alias addresses with data whose unused bits are set, then reads the combined word back. A simultaneous read and write to the same address exercises the pre-write read ordering. A full 4096-address read sweep covers decode.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned START_W = 16;
  localparam int unsigned FX_W    = 3;

  localparam logic [ADDR_W-1:0] A_START = 12'h008;
  localparam logic [ADDR_W-1:0] A_SAT   = 12'h009;
  localparam logic [ADDR_W-1:0] A_RND   = 12'h00A;
  localparam logic [ADDR_W-1:0] A_FX    = 12'h00F;
  localparam logic [ADDR_W-1:0] A_LEN   = 12'hC20;
  localparam logic [ADDR_W-1:0] A_TYPE  = 12'hC21;
  localparam logic [ADDR_W-1:0] A_LENB  = 12'hC22;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_START,
    SEL_SAT,
    SEL_RND,
    SEL_FX,
    SEL_LEN,
    SEL_TYPE,
    SEL_LENB
  } vcr_sel_e;
endpackage

// File: rtl/vcr_decode.sv
module vcr_decode
  import vcr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output vcr_sel_e          sel,
  output logic              hit
);
  always_comb begin
    case (addr)
      A_START: sel = SEL_START;
      A_SAT:   sel = SEL_SAT;
      A_RND:   sel = SEL_RND;
      A_FX:    sel = SEL_FX;
      A_LEN:   sel = SEL_LEN;
      A_TYPE:  sel = SEL_TYPE;
      A_LENB:  sel = SEL_LENB;
      default: sel = SEL_NONE;
    endcase
    hit = (sel != SEL_NONE);
  end
endmodule

// File: rtl/vcr_fxctl.sv
// Combined fixed-point control word: rounding mode in [2:1], saturation in [0].
// The two alias views write only their own field.
module vcr_fxctl
  import vcr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  vcr_sel_e        sel,
  input  logic [FX_W-1:0] wdata,
  output logic [FX_W-1:0] fx_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fx_q <= '0;
    end else if (we) begin
      case (sel)
        SEL_SAT: fx_q[0]   <= wdata[0];
        SEL_RND: fx_q[2:1] <= wdata[1:0];
        SEL_FX:  fx_q      <= wdata;
        default: fx_q      <= fx_q;
      endcase
    end
  end
endmodule

// File: rtl/vcr_start.sv
// Start-index register: keeps LOG low bits, upper bits forced to zero.
module vcr_start
  import vcr_pkg::*;
#(
  parameter int unsigned LOG = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [LOG-1:0]     d,
  output logic [START_W-1:0] q
);
  logic [START_W-1:0] d_ext;

  generate
    if (LOG < START_W) begin : g_pad
      assign d_ext = {{(START_W-LOG){1'b0}}, d};
    end else begin : g_full
      assign d_ext = d[START_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d_ext;
  end
endmodule

// File: rtl/vcr_word.sv
// Full-width register with a parameterized reset value.
module vcr_word #(
  parameter int unsigned   W   = 32,
  parameter logic [W-1:0]  RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST;
    else if (we) q <= d;
  end
endmodule

// File: rtl/vec_ctl_regs.sv
module vec_ctl_regs
  import vcr_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned VLEN_LOG = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [XLEN-1:0]   wr_data,
  output logic [XLEN-1:0]   rd_data,
  output logic              addr_hit,
  output logic [XLEN-1:0]   wr_result
);
  localparam int unsigned NWORD = 3;
  localparam logic [XLEN-1:0] TYPE_RST = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] LENB_RST = XLEN'((2 ** VLEN_LOG) / 8);
  localparam logic [NWORD*XLEN-1:0] WORD_RST = {LENB_RST, TYPE_RST, {XLEN{1'b0}}};

  vcr_sel_e              sel;
  logic                  hit;
  logic [FX_W-1:0]       fx_q;
  logic [START_W-1:0]    start_q;
  logic [XLEN-1:0]       word_q [NWORD];
  logic [XLEN-1:0]       rd_mux;
  logic [XLEN-1:0]       wr_mux;

  vcr_decode u_dec (
    .addr (csr_addr),
    .sel  (sel),
    .hit  (hit)
  );

  vcr_fxctl u_fx (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .sel   (sel),
    .wdata (wr_data[FX_W-1:0]),
    .fx_q  (fx_q)
  );

  vcr_start #(.LOG(VLEN_LOG)) u_start (
    .clk (clk),
    .rst (rst),
    .we  (wr_en && sel == SEL_START),
    .d   (wr_data[VLEN_LOG-1:0]),
    .q   (start_q)
  );

  // Full-width words: index 0 length, 1 type, 2 length in bytes.
  for (genvar g = 0; g < NWORD; g++) begin : g_word
    localparam vcr_sel_e MY_SEL = (g == 0) ? SEL_LEN : ((g == 1) ? SEL_TYPE : SEL_LENB);
    vcr_word #(.W(XLEN), .RST(WORD_RST[g*XLEN +: XLEN])) u_word (
      .clk (clk),
      .rst (rst),
      .we  (wr_en && sel == MY_SEL),
      .d   (wr_data),
      .q   (word_q[g])
    );
  end

  // Current contents, read view.
  always_comb begin
    case (sel)
      SEL_START: rd_mux = XLEN'(start_q);
      SEL_SAT:   rd_mux = XLEN'(fx_q[0]);
      SEL_RND:   rd_mux = XLEN'(fx_q[2:1]);
      SEL_FX:    rd_mux = XLEN'(fx_q);
      SEL_LEN:   rd_mux = word_q[0];
      SEL_TYPE:  rd_mux = word_q[1];
      SEL_LENB:  rd_mux = word_q[2];
      default:   rd_mux = '0;
    endcase
  end

  // Value that the current write will leave stored, in read form.
  always_comb begin
    case (sel)
      SEL_START: wr_mux = XLEN'(wr_data[VLEN_LOG-1:0]);
      SEL_SAT:   wr_mux = XLEN'(wr_data[0]);
      SEL_RND:   wr_mux = XLEN'(wr_data[1:0]);
      SEL_FX:    wr_mux = XLEN'(wr_data[FX_W-1:0]);
      SEL_LEN,
      SEL_TYPE,
      SEL_LENB:  wr_mux = wr_data;
      default:   wr_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      addr_hit  <= 1'b0;
      wr_result <= '0;
    end else begin
      rd_data   <= rd_en ? rd_mux : '0;
      addr_hit  <= (rd_en || wr_en) && hit;
      wr_result <= wr_en ? wr_mux : '0;
    end
  end
endmodule

// File: rtl/vcr_chk.sv
module vcr_chk #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned VLEN_LOG = 7
) (
  input logic            clk,
  input logic            rst,
  input logic [11:0]     csr_addr,
  input logic            rd_en,
  input logic            wr_en,
  input logic [XLEN-1:0] wr_data,
  input logic [XLEN-1:0] rd_data,
  input logic            addr_hit,
  input logic [XLEN-1:0] wr_result,
  input logic [2:0]      fx_q
);
  logic known;
  assign known = (csr_addr == 12'h008) || (csr_addr == 12'h009) ||
                 (csr_addr == 12'h00A) || (csr_addr == 12'h00F) ||
                 (csr_addr == 12'hC20) || (csr_addr == 12'hC21) ||
                 (csr_addr == 12'hC22);

  // R2
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !known) |=> (rd_data == '0 && !addr_hit));

  // R1
  hit_on_known_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && known) |=> addr_hit);

  // R4
  sat_keeps_rnd_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && csr_addr == 12'h009) |=>
      (fx_q[2:1] == $past(fx_q[2:1]) && fx_q[0] == $past(wr_data[0])));

  // R5
  rnd_keeps_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && csr_addr == 12'h00A) |=>
      (fx_q[0] == $past(fx_q[0]) && fx_q[2:1] == $past(wr_data[1:0])));

  // R7
  start_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && csr_addr == 12'h008) |=> (rd_data[XLEN-1:VLEN_LOG] == '0));

  // R12
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));

  // R9
  idle_write_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (wr_result == '0));

  // R13
  undef_write_keeps_fx_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !known) |=> $stable(fx_q));
endmodule

bind vec_ctl_regs vcr_chk #(.XLEN(XLEN), .VLEN_LOG(VLEN_LOG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .csr_addr  (csr_addr),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .addr_hit  (addr_hit),
  .wr_result (wr_result),
  .fx_q      (fx_q)
);

// File: tb/vec_ctl_regs_bench.sv
module vec_ctl_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int VLEN_LOG = 7;

  logic            clk = 1'b0;
  logic            rst;
  logic [11:0]     csr_addr;
  logic            rd_en, wr_en;
  logic [XLEN-1:0] wr_data;
  logic [XLEN-1:0] rd_data;
  logic            addr_hit;
  logic [XLEN-1:0] wr_result;

  int checks = 0;
  int failures = 0;

  logic [15:0]     m_start;
  logic [2:0]      m_fx;
  logic [XLEN-1:0] m_len, m_type, m_lenb;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_ctl_regs #(.XLEN(XLEN), .VLEN_LOG(VLEN_LOG)) u_vec_ctl_regs (
    .clk (clk), .rst (rst), .csr_addr (csr_addr), .rd_en (rd_en),
    .wr_en (wr_en), .wr_data (wr_data), .rd_data (rd_data),
    .addr_hit (addr_hit), .wr_result (wr_result)
  );

  function automatic logic is_def(input logic [11:0] a);
    return a == 12'h008 || a == 12'h009 || a == 12'h00A || a == 12'h00F ||
           a == 12'hC20 || a == 12'hC21 || a == 12'hC22;
  endfunction

  function automatic logic [XLEN-1:0] m_read(input logic [11:0] a);
    case (a)
      12'h008: return {16'h0, m_start};
      12'h009: return {31'h0, m_fx[0]};
      12'h00A: return {30'h0, m_fx[2:1]};
      12'h00F: return {29'h0, m_fx};
      12'hC20: return m_len;
      12'hC21: return m_type;
      12'hC22: return m_lenb;
      default: return '0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] m_write(input logic [11:0] a, input logic [XLEN-1:0] d);
    case (a)
      12'h008: m_start = 16'(d % (2 ** VLEN_LOG));
      12'h009: m_fx[0] = d[0];
      12'h00A: m_fx[2:1] = d[1:0];
      12'h00F: m_fx = d[2:0];
      12'hC20: m_len = d;
      12'hC21: m_type = d;
      12'hC22: m_lenb = d;
      default: ;
    endcase
    return m_read(a);
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // Inputs driven after a falling edge, sampled at the next falling edge.
  task automatic access(input logic [11:0] a, input logic r, input logic w,
                        input logic [XLEN-1:0] d, input string tag);
    logic [XLEN-1:0] e_rd, e_wr;
    logic e_hit;
    e_rd  = r ? m_read(a) : '0;
    e_hit = (r || w) && is_def(a);
    e_wr  = w ? m_write(a, d) : '0;
    csr_addr = a; rd_en = r; wr_en = w; wr_data = d;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check(tag, "rd_data", rd_data, e_rd);
    check(tag, "addr_hit", {31'h0, addr_hit}, {31'h0, e_hit});
    check(tag, "wr_result", wr_result, e_wr);
  endtask

  task automatic read_all(input string tag);
    access(12'h008, 1, 0, 0, tag); access(12'h009, 1, 0, 0, tag);
    access(12'h00A, 1, 0, 0, tag); access(12'h00F, 1, 0, 0, tag);
    access(12'hC20, 1, 0, 0, tag); access(12'hC21, 1, 0, 0, tag);
    access(12'hC22, 1, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired got=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; csr_addr = '0; rd_en = 0; wr_en = 0; wr_data = '0;
    m_start = '0; m_fx = '0; m_len = '0;
    m_type = 32'h8000_0000; m_lenb = 32'd16;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset contents
    read_all("R10");

    // R1 R2 R3: full address sweep
    for (int a = 0; a < 4096; a++) access(12'(a), 1, 0, 0, "R1_R2");

    // R4 R5 R6 R3: every combined value preloaded, then each alias written
    for (int v = 0; v < 8; v++) begin
      for (int s = 0; s < 2; s++) begin
        access(12'h00F, 0, 1, 32'(v) | 32'hFFFF_FFF8, "R6");
        access(12'h009, 0, 1, 32'(s) | 32'hFFFF_FFFE, "R4");
        access(12'h00F, 1, 0, 0, "R4");
        access(12'h00A, 1, 0, 0, "R3");
        access(12'h009, 1, 0, 0, "R3");
      end
      for (int r = 0; r < 4; r++) begin
        access(12'h00F, 0, 1, 32'(v), "R6");
        access(12'h00A, 0, 1, 32'(r) | 32'hFFFF_FFFC, "R5");
        access(12'h00F, 1, 0, 0, "R5");
      end
    end

    // R7: start index masking
    access(12'h008, 0, 1, 32'hFFFF_FFFF, "R7");
    access(12'h008, 1, 0, 0, "R7");
    access(12'h008, 0, 1, 32'h0001_2345, "R7");
    access(12'h008, 1, 0, 0, "R7");
    access(12'h008, 0, 1, 32'h0000_0080, "R7");
    access(12'h008, 1, 0, 0, "R7");

    // R8 R9: full-width words
    access(12'hC20, 0, 1, 32'hDEAD_BEEF, "R8");
    access(12'hC21, 0, 1, 32'h7FFF_FFFF, "R8");
    access(12'hC22, 0, 1, 32'hA5A5_5A5A, "R9");
    read_all("R8");

    // R11: read and write together return the old value, new one after
    access(12'hC20, 1, 1, 32'h1234_5678, "R11");
    access(12'hC20, 1, 0, 0, "R11");
    access(12'h00A, 1, 1, 32'h2, "R11");
    access(12'h00A, 1, 0, 0, "R11");

    // R13 R9: writes to undefined addresses alter nothing
    access(12'h00B, 0, 1, 32'hFFFF_FFFF, "R13");
    access(12'hC23, 0, 1, 32'hFFFF_FFFF, "R13");
    access(12'h007, 1, 1, 32'hFFFF_FFFF, "R13");
    read_all("R13");

    // R12: no strobe gives zero read data
    access(12'hC20, 0, 0, 0, "R12");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule